// File: doc/BRIEF.md
# Binary-Weighted Phase-Shift Gate Generator

This block drives the gate commands of 2^K identical full-bridge modules whose outputs are stacked in series to build a staircase approximation of a sine wave. Every module receives the same fundamental-frequency square wave at exactly 50% duty. The modules differ only in how far that wave is delayed. Each module's delay is built from a small table of harmonic-cancelling offsets, one offset per harmonic: the k-th bit of the module's zero-based index decides whether offset k is added to its delay.

The offsets are meant to be about period/(2n) for the harmonics n = 3, 5, 7, 11, 13, 17, taken in that order. Combining the delayed waves then removes those harmonics one after another. A sync pulse starts the period counter and captures the period length and the offset table. Changes on those inputs stay invisible until the next sync pulse. The block also reports the phase lag of the combined fundamental, so that the carrier can be compensated.

Top module: `stair_gate_gen`

## Requirements
- R1: After reset and until the first sync pulse, every gate output is 0 and `refPhase` is 0.
- R2: A clock edge that samples `syncPulse` high restarts the tick counter at 0. The same edge captures `periodTicks` as P and the offset table. This holds on every sync pulse, including back-to-back ones.
- R3: After a sync pulse the tick counter repeats 0, 1, …, P-1 with no gaps, for any P ≥ 2.
- R4: The module with zero-based index i has delay D_i. D_i is the sum of offset k over every bit k that is set in i. Offset k is the field `offsetTable[k*CNT_W +: CNT_W]`, in ticks. D_0 = 0, and the last module's delay is the sum of all offsets. Every D_i must be less than P.
- R5: Output bit i is 1 when ((t − D_i) mod P) < floor(P/2), where t is the counter value held during the previous clock cycle. Each wave therefore rises at tick D_i and stays high for floor(P/2) ticks of every period.
- R6: Changing `periodTicks` or `offsetTable` without a sync pulse has no effect on the outputs.
- R7: `refPhase` equals floor(sum of all captured offsets / 2). It takes the new value on the edge that captures the table.
- R8: A sync pulse that arrives in the middle of a period restarts the cycle at once with the newly captured values.
- R9: For an odd P, each output is high for floor(P/2) ticks and low for ceil(P/2) ticks. At P = 2 each output toggles every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| syncPulse | input | 1 | Starts a new period and captures the settings |
| periodTicks | input | CNT_W | Length of the fundamental period, in ticks |
| offsetTable | input | K*CNT_W | Harmonic-cancelling offsets in ticks; entry k is held at bits k*CNT_W and up |
| gateOut | output | 2**K | One square-wave gate command per module |
| refPhase | output | CNT_W | Phase lag of the combined fundamental, in ticks |

## Verification
The gate outputs lag the counter by one register. A behavioural model in the bench therefore computes each cycle's expected gates from the tick value it held before that edge, and it moves its own counter only after that. `refPhase` is a combinational function of the captured offsets, so the model updates it on the capturing edge itself. All outputs are compared on the falling edge that follows. The bench changes its inputs only on falling edges and compares every cycle. Each cycle is labelled with the requirement that the current stimulus targets: odd and minimal periods, changes to the inputs without a sync pulse, and sync pulses in the middle of a period or on consecutive cycles.

// File: rtl/sgg_pkg.sv
package sgg_pkg;
  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic loadTable;  // capture the offset table on this edge
    logic active;     // counter is running (a sync pulse has been seen)
  } sggStrobe_t;
endpackage

// File: rtl/sgg_ctrl.sv
module sgg_ctrl
  import sgg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             syncPulse,
  input  logic [CNT_W-1:0] periodIn,
  output sggStrobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] periodQ
);
  logic             activeQ;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = periodQ - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      periodQ <= '0;
      activeQ <= 1'b0;
    end else if (syncPulse) begin
      cnt     <= '0;
      periodQ <= periodIn;
      activeQ <= 1'b1;
    end else if (activeQ) begin
      cnt <= (cnt == lastCnt) ? '0 : cnt + CNT_W'(1);
    end
  end

  assign strobe.loadTable = syncPulse;
  assign strobe.active    = activeQ;

  // R2: a sync pulse restarts the count and arms the generator
  p_sync_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    syncPulse |=> (cnt == '0 && strobe.active));
  // R3: the count wraps to zero after the last tick of the period
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ && !syncPulse && cnt == lastCnt) |=> cnt == '0);
  // R3: otherwise the count advances by exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ && !syncPulse && cnt != lastCnt) |=> cnt == $past(cnt) + CNT_W'(1));
  // R6: the captured period only changes on a sync pulse
  p_period_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !syncPulse |=> $stable(periodQ));
endmodule

// File: rtl/sgg_datapath.sv
module sgg_datapath
  import sgg_pkg::*;
#(
  parameter int K     = 3,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sggStrobe_t           strobe,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [CNT_W-1:0]     periodQ,
  input  logic [K*CNT_W-1:0]   offsetIn,
  output logic [(1<<K)-1:0]    gateOut,
  output logic [CNT_W-1:0]     refPhase
);
  localparam int NUM_MOD = 1 << K;
  localparam int SUM_W   = CNT_W + $clog2(K + 1);
  localparam int PH_W    = SUM_W + 1;

  logic [CNT_W-1:0]   offQ [K];
  logic [NUM_MOD-1:0] gateNext;
  logic [SUM_W-1:0]   totalDly;
  logic [PH_W-1:0]    halfPeriod;

  // Shadow copy of the offset table, refreshed only on sync
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < K; k++) offQ[k] <= '0;
    end else if (strobe.loadTable) begin
      for (int k = 0; k < K; k++) offQ[k] <= offsetIn[k*CNT_W +: CNT_W];
    end
  end

  assign halfPeriod = PH_W'(periodQ >> 1);

  // One delay adder and phase comparator per module
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    logic [SUM_W-1:0] dly;
    logic [PH_W-1:0]  raw;
    logic [PH_W-1:0]  wrapped;

    always_comb begin
      dly = '0;
      for (int k = 0; k < K; k++) begin
        if (((m >> k) & 1) == 1) dly = dly + SUM_W'(offQ[k]);
      end
    end

    assign raw      = PH_W'(cnt) + PH_W'(periodQ) - PH_W'(dly);
    assign wrapped  = (raw >= PH_W'(periodQ)) ? raw - PH_W'(periodQ) : raw;
    assign gateNext[m] = strobe.active && (wrapped < halfPeriod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gateOut <= '0;
    else        gateOut <= gateNext;
  end

  always_comb begin
    totalDly = '0;
    for (int k = 0; k < K; k++) totalDly = totalDly + SUM_W'(offQ[k]);
  end
  assign refPhase = CNT_W'(totalDly >> 1);

  // R1: gates stay low while the counter is not armed
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.active |=> gateOut == '0);
  // R1: no reference phase before the first sync
  p_ref_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.active |-> refPhase == '0);
  // R5: the undelayed module is high on the first tick of a period
  p_first_module_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.active && cnt == '0 && periodQ >= CNT_W'(2)) |=> gateOut[0]);
  // R6: the reference phase cannot move without a table load
  p_table_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadTable |=> $stable(refPhase));
endmodule

// File: rtl/stair_gate_gen.sv
module stair_gate_gen
  import sgg_pkg::*;
#(
  parameter int K     = 3,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 syncPulse,
  input  logic [CNT_W-1:0]     periodTicks,
  input  logic [K*CNT_W-1:0]   offsetTable,
  output logic [(1<<K)-1:0]    gateOut,
  output logic [CNT_W-1:0]     refPhase
);
  sggStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodQ;

  sgg_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .syncPulse(syncPulse),
    .periodIn (periodTicks),
    .strobe   (strobe),
    .cnt      (cnt),
    .periodQ  (periodQ)
  );

  sgg_datapath #(.K(K), .CNT_W(CNT_W)) i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .cnt     (cnt),
    .periodQ (periodQ),
    .offsetIn(offsetTable),
    .gateOut (gateOut),
    .refPhase(refPhase)
  );
endmodule

// File: tb/test_stair_gate_gen.sv
module test_stair_gate_gen;
  localparam int K = 3;
  localparam int W = 16;
  localparam int NM = 1 << K;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           syncPulse = 1'b0;
  logic [W-1:0]   periodTicks = '0;
  logic [K*W-1:0] offsetTable = '0;
  logic [NM-1:0]  gateOut;
  logic [W-1:0]   refPhase;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit compareOn = 0;
  string curReq = "R1";

  // Behavioural reference state
  int mCnt = 0, mP = 0, mActive = 0, mRef = 0;
  int mOff [K];
  logic [NM-1:0] mGate = '0;

  stair_gate_gen #(.K(K), .CNT_W(W)) i_stair_gate_gen (
    .clk(clk), .rst_n(rst_n), .syncPulse(syncPulse),
    .periodTicks(periodTicks), .offsetTable(offsetTable),
    .gateOut(gateOut), .refPhase(refPhase)
  );

  always #10 clk = ~clk;

  // R4/R5: expected wave from the model's tick value before the edge
  function automatic logic [NM-1:0] expGates(int t);
    logic [NM-1:0] g = '0;
    for (int i = 0; i < NM; i++) begin
      int d = 0;
      int ph;
      for (int k = 0; k < K; k++) if ((i >> k) & 1) d += mOff[k];
      ph = (((t - d) % mP) + mP) % mP;
      g[i] = (ph < mP / 2);
    end
    return g;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mCnt = 0; mP = 0; mActive = 0; mGate = '0; mRef = 0;
      for (int k = 0; k < K; k++) mOff[k] = 0;
    end else begin
      logic [NM-1:0] nextG;
      int s;
      nextG = (mActive != 0 && mP > 0) ? expGates(mCnt) : '0;
      if (syncPulse) begin
        mCnt = 0; mActive = 1; mP = int'(periodTicks);
        for (int k = 0; k < K; k++) mOff[k] = int'(offsetTable[k*W +: W]);
      end else if (mActive != 0) begin
        mCnt = (mCnt == mP - 1) ? 0 : mCnt + 1;
      end
      mGate = nextG;
      s = 0;
      for (int k = 0; k < K; k++) s += mOff[k];
      mRef = s / 2;
    end
  end

  always @(negedge clk) begin
    if (compareOn) begin
      checks++;
      if (gateOut !== mGate) begin
        failures++;
        $display("FAIL %s gateOut actual=%b expected=%b", curReq, gateOut, mGate);
      end
      checks++;
      if (int'(refPhase) != mRef) begin
        failures++;
        $display("FAIL R7 refPhase actual=%0d expected=%0d", refPhase, mRef);
      end
    end
  end

  task automatic setTable(int o0, int o1, int o2);
    offsetTable = {W'(o2), W'(o1), W'(o0)};
  endtask

  task automatic pulseSync(int p, int o0, int o1, int o2);
    @(negedge clk);
    periodTicks = W'(p);
    setTable(o0, o1, o2);
    syncPulse = 1'b1;
    @(negedge clk);
    syncPulse = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state and behaviour before any sync
    curReq = "R1";
    compareOn = 1;
    idle(3);
    rst_n = 1'b1;
    periodTicks = W'(30);
    setTable(5, 3, 2);
    idle(6);
    // R2, R3, R4, R5: period of 60 ticks, offsets about P/6, P/10, P/14
    curReq = "R2";
    pulseSync(60, 10, 6, 4);
    curReq = "R3/R4/R5";
    idle(130);
    // R6: inputs change without a sync pulse
    curReq = "R6";
    periodTicks = W'(40);
    setTable(1, 2, 3);
    idle(70);
    // R9: odd period
    curReq = "R9";
    pulseSync(41, 7, 4, 3);
    idle(90);
    // R8: sync in the middle of a period
    curReq = "R8";
    pulseSync(24, 4, 2, 2);
    idle(17);
    pulseSync(24, 3, 2, 1);
    idle(60);
    // R2: sync pulses on consecutive cycles
    curReq = "R2";
    @(negedge clk);
    periodTicks = W'(20); setTable(3, 2, 1); syncPulse = 1'b1;
    @(negedge clk);
    periodTicks = W'(28); setTable(5, 3, 2);
    @(negedge clk);
    syncPulse = 1'b0;
    idle(60);
    // R9: smallest period
    curReq = "R9";
    pulseSync(2, 0, 0, 1);
    idle(12);
    compareOn = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule